// File: doc/BRIEF.md
# Two-Level Interrupt Controller with Fast/Normal Routing

This controller gathers interrupt events from three kinds of input: main sources, external lines and grouped sub-sources. It holds each event in a pending register until software clears it. Each main source bit can be masked. A per-bit route register then sends every unmasked pending source to one of two active-low request outputs: the fast one (`fiq_n`) or the normal one (`irq_n`). Sub-sources come in groups of three. An unmasked sub-pending bit raises its group's parent bit in the main pending register. Unmasked external pending bits all raise one shared parent source.

Whenever a normal-routed request is active and the in-service register is empty, the block loads the in-service register. It places a one-hot copy of the lowest-numbered normal-routed effective request there and stores that request's number in a read-only index register. Software reaches every register over a 32-bit word-addressed bus. Reads return data one cycle after the address is presented. Writes take effect on the clock edge that samples them.

Register word addresses are:

| Address | Register |
|---|---|
| 0 | source pending |
| 1 | route |
| 2 | source mask |
| 3 | in-service |
| 4 | in-service index |
| 5 | sub pending |
| 6 | sub mask |
| 7 | external pending |
| 8 | external mask |

Top module: `dual_route_intc`

## Requirements
- R1: A source bit is effective only if it is pending, its mask bit (address 2, 1 = blocked) is 0, and it is implemented. Bit 31 is not implemented: it never becomes pending and never drives an output.
- R2: `fiq_n` is 0 exactly when an effective source has its route bit (address 1) at 1. Otherwise it is 1.
- R3: `irq_n` is 0 exactly when an effective source has its route bit at 0. Otherwise it is 1.
- R4: A write to source pending (address 0) clears the bits written as 1 and keeps the bits written as 0. Both outputs show the new state right after that same clock edge.
- R5: A write to the source mask changes both outputs right after that same clock edge.
- R6: A write to in-service (address 3) clears the bits written as 1 and sets the index register to 0.
- R7: When in-service is 0 and a route-0 effective source exists, the next edge loads in-service with a one-hot copy of the lowest such source and loads the index with its bit number. Sources routed to 1 are never loaded.
- R8: Sub pending (address 5) latches `sub_req` and is write-1-to-clear. Bit 8 is not implemented and always reads 0.
- R9: A sub-pending bit whose sub-mask bit (address 6) is 0 sets main source 28 + (bit number / 3) one cycle later. A blocked sub-pending bit sets nothing.
- R10: External pending (address 7) latches only `ext_req` bits 4 to 23 and is write-1-to-clear. Any such bit whose external-mask bit (address 8) is 0 sets main source 5 one cycle later.
- R11: The index register (address 4) is read-only. A write to it changes nothing.
- R12: If a set event and a clearing write hit the same pending bit on the same edge, the bit stays set.
- R13: After reset, both outputs are 1. All pending, route, in-service and index registers are 0. All mask registers are all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_sel | input | 1 | Bus access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after the access |
| src_req | input | 32 | Main source events, sampled every edge |
| sub_req | input | 9 | Sub-source events, three per group |
| ext_req | input | 32 | External line events, bits 4 to 23 used |
| fiq_n | output | 1 | Fast request, active low |
| irq_n | output | 1 | Normal request, active low |

## Verification
The assertions assume the bus presents only one access per cycle. They also assume a write to in-service is never combined with an expected reload on the same edge. The bench meets both assumptions by driving every input on the falling edge and holding each access for exactly one cycle. Event inputs are pulsed for a single cycle, except in the one collision test that deliberately holds a source high during its own clearing write. Between scenarios the bench clears source pending before in-service, so no stale request reloads the in-service register.

// File: rtl/drintc_pkg.sv
package drintc_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 4;
  localparam int SRC_N  = 32;
  localparam int IDX_W  = $clog2(SRC_N);
  localparam int GRP_SZ = 3;

  typedef enum logic [ADDR_W-1:0] {
    RA_SRC_PEND = 4'd0,
    RA_ROUTE    = 4'd1,
    RA_MASK     = 4'd2,
    RA_SVC      = 4'd3,
    RA_SVC_IDX  = 4'd4,
    RA_SUB_PEND = 4'd5,
    RA_SUB_MASK = 4'd6,
    RA_EXT_PEND = 4'd7,
    RA_EXT_MASK = 4'd8
  } reg_addr_e;
endpackage

// File: rtl/drintc_w1c_bank.sv
module drintc_w1c_bank #(
  parameter int            W    = 32,
  parameter logic [W-1:0]  IMPL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic         clr_en_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] pend_d_o,
  output logic [W-1:0] pend_q_o
);
  logic [W-1:0] clr_eff;

  always_comb begin
    clr_eff  = clr_en_i ? clr_i : '0;
    // set wins over a same-edge clear
    pend_d_o = ((pend_q_o & ~clr_eff) | set_i) & IMPL;
  end

  always_ff @(posedge clk) begin
    if (rst) pend_q_o <= '0;
    else     pend_q_o <= pend_d_o;
  end

  p_set_kept_r12: assert property (@(posedge clk) disable iff (rst)
    (|(set_i & IMPL)) |=> ((pend_q_o & $past(set_i & IMPL)) == $past(set_i & IMPL)));
endmodule

// File: rtl/drintc_group_or.sv
module drintc_group_or #(
  parameter int N_GRP = 3,
  parameter int G_SZ  = 3
) (
  input  logic [N_GRP*G_SZ-1:0] pend_i,
  input  logic [N_GRP*G_SZ-1:0] mask_i,
  output logic [N_GRP-1:0]      hit_o
);
  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    assign hit_o[g] = |(pend_i[g*G_SZ +: G_SZ] & ~mask_i[g*G_SZ +: G_SZ]);
  end
endmodule

// File: rtl/drintc_pick.sv
module drintc_pick #(
  parameter int W  = 32,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0]  req_i,
  output logic          hit_o,
  output logic [W-1:0]  onehot_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    hit_o    = 1'b0;
    onehot_o = '0;
    idx_o    = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        hit_o       = 1'b1;
        onehot_o    = '0;
        onehot_o[i] = 1'b1;
        idx_o       = IW'(i);
      end
    end
  end
endmodule

// File: rtl/dual_route_intc.sv
module dual_route_intc
  import drintc_pkg::*;
#(
  parameter int                  N_GRP      = 3,
  parameter int                  SUB_BASE   = 28,
  parameter int                  EXT_PARENT = 5,
  parameter logic [31:0]         SRC_IMPL   = 32'h7FFF_FFFF,
  parameter logic [3*N_GRP-1:0]  SUB_IMPL   = 'h0FF,
  parameter logic [31:0]         EXT_IMPL   = 32'h00FF_FFF0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 reg_sel,
  input  logic                 reg_wr,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [DATA_W-1:0]    reg_wdata,
  output logic [DATA_W-1:0]    reg_rdata,
  input  logic [SRC_N-1:0]     src_req,
  input  logic [3*N_GRP-1:0]   sub_req,
  input  logic [DATA_W-1:0]    ext_req,
  output logic                 fiq_n,
  output logic                 irq_n
);
  localparam int SUB_W = GRP_SZ * N_GRP;

  logic we_src, we_route, we_mask, we_svc, we_idx;
  logic we_sub, we_submask, we_ext, we_extmask;

  always_comb begin
    we_src     = reg_sel && reg_wr && (reg_addr == RA_SRC_PEND);
    we_route   = reg_sel && reg_wr && (reg_addr == RA_ROUTE);
    we_mask    = reg_sel && reg_wr && (reg_addr == RA_MASK);
    we_svc     = reg_sel && reg_wr && (reg_addr == RA_SVC);
    we_idx     = reg_sel && reg_wr && (reg_addr == RA_SVC_IDX);
    we_sub     = reg_sel && reg_wr && (reg_addr == RA_SUB_PEND);
    we_submask = reg_sel && reg_wr && (reg_addr == RA_SUB_MASK);
    we_ext     = reg_sel && reg_wr && (reg_addr == RA_EXT_PEND);
    we_extmask = reg_sel && reg_wr && (reg_addr == RA_EXT_MASK);
  end

  // plain control registers
  logic [SRC_N-1:0]  route_q, route_d, mask_q, mask_d;
  logic [SUB_W-1:0]  submask_q;
  logic [DATA_W-1:0] extmask_q;

  always_comb begin
    route_d = we_route ? reg_wdata : route_q;
    mask_d  = we_mask  ? reg_wdata : mask_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      route_q   <= '0;
      mask_q    <= '1;
      submask_q <= '1;
      extmask_q <= '1;
    end else begin
      route_q <= route_d;
      mask_q  <= mask_d;
      if (we_submask) submask_q <= reg_wdata[SUB_W-1:0];
      if (we_extmask) extmask_q <= reg_wdata;
    end
  end

  // sub-source layer
  logic [SUB_W-1:0] sub_d, sub_q;
  logic [N_GRP-1:0] grp_hit;

  drintc_w1c_bank #(.W(SUB_W), .IMPL(SUB_IMPL)) u_sub_bank (
    .clk(clk), .rst(rst), .set_i(sub_req), .clr_en_i(we_sub),
    .clr_i(reg_wdata[SUB_W-1:0]), .pend_d_o(sub_d), .pend_q_o(sub_q)
  );

  drintc_group_or #(.N_GRP(N_GRP), .G_SZ(GRP_SZ)) u_grp (
    .pend_i(sub_q), .mask_i(submask_q), .hit_o(grp_hit)
  );

  // external layer
  logic [DATA_W-1:0] ext_d, ext_q;
  logic              ext_hit;

  drintc_w1c_bank #(.W(DATA_W), .IMPL(EXT_IMPL)) u_ext_bank (
    .clk(clk), .rst(rst), .set_i(ext_req), .clr_en_i(we_ext),
    .clr_i(reg_wdata), .pend_d_o(ext_d), .pend_q_o(ext_q)
  );

  assign ext_hit = |(ext_q & ~extmask_q);

  // main source layer
  logic [SRC_N-1:0] parent_vec, src_set, src_d, src_q;

  always_comb begin
    parent_vec = '0;
    for (int g = 0; g < N_GRP; g++) parent_vec[SUB_BASE + g] = grp_hit[g];
    parent_vec[EXT_PARENT] = parent_vec[EXT_PARENT] | ext_hit;
    src_set = src_req | parent_vec;
  end

  drintc_w1c_bank #(.W(SRC_N), .IMPL(SRC_IMPL)) u_src_bank (
    .clk(clk), .rst(rst), .set_i(src_set), .clr_en_i(we_src),
    .clr_i(reg_wdata), .pend_d_o(src_d), .pend_q_o(src_q)
  );

  // routed outputs follow the next-state values
  always_ff @(posedge clk) begin
    if (rst) begin
      fiq_n <= 1'b1;
      irq_n <= 1'b1;
    end else begin
      fiq_n <= ~|(src_d & ~mask_d &  route_d & SRC_IMPL);
      irq_n <= ~|(src_d & ~mask_d & ~route_d & SRC_IMPL);
    end
  end

  // in-service register and index
  logic [SRC_N-1:0] normal_vec, pick_oh, svc_q;
  logic [IDX_W-1:0] pick_idx, svc_idx_q;
  logic             pick_hit;

  assign normal_vec = src_q & ~mask_q & ~route_q & SRC_IMPL;

  drintc_pick #(.W(SRC_N), .IW(IDX_W)) u_pick (
    .req_i(normal_vec), .hit_o(pick_hit), .onehot_o(pick_oh), .idx_o(pick_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      svc_q     <= '0;
      svc_idx_q <= '0;
    end else if (we_svc) begin
      svc_q     <= svc_q & ~reg_wdata;
      svc_idx_q <= '0;
    end else if ((svc_q == '0) && pick_hit) begin
      svc_q     <= pick_oh;
      svc_idx_q <= pick_idx;
    end
  end

  // registered read path
  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_sel && !reg_wr) begin
      case (reg_addr)
        RA_SRC_PEND: reg_rdata <= src_q;
        RA_ROUTE:    reg_rdata <= route_q;
        RA_MASK:     reg_rdata <= mask_q;
        RA_SVC:      reg_rdata <= svc_q;
        RA_SVC_IDX:  reg_rdata <= {{(DATA_W-IDX_W){1'b0}}, svc_idx_q};
        RA_SUB_PEND: reg_rdata <= {{(DATA_W-SUB_W){1'b0}}, sub_q};
        RA_SUB_MASK: reg_rdata <= {{(DATA_W-SUB_W){1'b0}}, submask_q};
        RA_EXT_PEND: reg_rdata <= ext_q;
        RA_EXT_MASK: reg_rdata <= extmask_q;
        default:     reg_rdata <= '0;
      endcase
    end
  end

  p_fiq_cause_r2: assert property (@(posedge clk) disable iff (rst)
    !fiq_n |-> (|(src_q & ~mask_q & route_q & SRC_IMPL)));
  p_irq_cause_r3: assert property (@(posedge clk) disable iff (rst)
    !irq_n |-> (|(src_q & ~mask_q & ~route_q & SRC_IMPL)));
  p_svc_onehot_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(svc_q));
  p_svc_idx_clear_r6: assert property (@(posedge clk) disable iff (rst)
    we_svc |=> (svc_idx_q == '0));
  p_idx_readonly_r11: assert property (@(posedge clk) disable iff (rst)
    (we_idx && (svc_q != '0)) |=> $stable(svc_idx_q));
endmodule

// File: tb/dual_route_intc_bench.sv
`timescale 1ns/1ps
module dual_route_intc_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_sel = 1'b0, reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] src_req = '0;
  logic [8:0]  sub_req = '0;
  logic [31:0] ext_req = '0;
  logic        fiq_n, irq_n;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  dual_route_intc u_dual_route_intc (
    .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .src_req(src_req), .sub_req(sub_req), .ext_req(ext_req),
    .fiq_n(fiq_n), .irq_n(irq_n)
  );

  localparam logic [3:0] A_SRC = 4'd0, A_ROUTE = 4'd1, A_MASK = 4'd2, A_SVC = 4'd3,
                         A_IDX = 4'd4, A_SUB = 4'd5, A_SUBM = 4'd6, A_EXT = 4'd7,
                         A_EXTM = 4'd8;

  // {mask, route, pulse, exp fiq_n, exp irq_n}
  localparam logic [97:0] VECS [8] = '{
    {32'h0000_0000, 32'h0000_0000, 32'h0000_0001, 1'b1, 1'b0},
    {32'h0000_0000, 32'h0000_0001, 32'h0000_0001, 1'b0, 1'b1},
    {32'h0000_0001, 32'h0000_0000, 32'h0000_0001, 1'b1, 1'b1},
    {32'h0000_0000, 32'h0000_0002, 32'h0000_0003, 1'b0, 1'b0},
    {32'h0000_0000, 32'h0000_0000, 32'h8000_0000, 1'b1, 1'b1},
    {32'hFFFF_FFF0, 32'h0000_0010, 32'h0000_0018, 1'b1, 1'b0},
    {32'h0000_0000, 32'hFFFF_FFFF, 32'h0400_0000, 1'b0, 1'b1},
    {32'hFFFF_FFFF, 32'h0000_0000, 32'hFFFF_FFFF, 1'b1, 1'b1}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_sel = 1'b0; reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    reg_sel = 1'b1; reg_wr = 1'b0; reg_addr = a;
    @(negedge clk);
    v = reg_rdata;
    reg_sel = 1'b0;
  endtask

  task automatic pulse_src(input logic [31:0] p);
    src_req = p;
    @(negedge clk);
    src_req = '0;
  endtask

  task automatic clean();
    wr(A_SRC, 32'hFFFF_FFFF);
    wr(A_SVC, 32'hFFFF_FFFF);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("%0d/%0d checks passed", n_chk + 1 - n_bad, n_chk + 1);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R13 reset state
    chk("R13 fiq_n", {31'b0, fiq_n}, 32'd1);
    chk("R13 irq_n", {31'b0, irq_n}, 32'd1);
    rd(A_MASK, v); chk("R13 mask", v, 32'hFFFF_FFFF);
    rd(A_SRC, v);  chk("R13 src pend", v, 32'h0);
    rd(A_SUBM, v); chk("R13 sub mask", v, 32'h0000_01FF);
    rd(A_IDX, v);  chk("R13 index", v, 32'h0);

    // R1 R2 R3 table walk
    foreach (VECS[i]) begin
      wr(A_ROUTE, VECS[i][65:34]);
      wr(A_MASK,  VECS[i][97:66]);
      pulse_src(VECS[i][33:2]);
      chk($sformatf("R2 fiq_n vec%0d", i), {31'b0, fiq_n}, {31'b0, VECS[i][1]});
      chk($sformatf("R3 irq_n vec%0d", i), {31'b0, irq_n}, {31'b0, VECS[i][0]});
      clean();
    end
    rd(A_SRC, v); chk("R1 bit31 never pends", v, 32'h0);

    // R4 write-1-to-clear with immediate output update
    wr(A_MASK, 32'h0); wr(A_ROUTE, 32'h0);
    pulse_src(32'h6);
    rd(A_SRC, v); chk("R4 pend before clear", v, 32'h6);
    wr(A_SRC, 32'h2);
    chk("R4 irq_n still low", {31'b0, irq_n}, 32'd0);
    rd(A_SRC, v); chk("R4 partial clear", v, 32'h4);
    wr(A_SRC, 32'h4);
    chk("R4 irq_n high at once", {31'b0, irq_n}, 32'd1);
    wr(A_SVC, 32'hFFFF_FFFF);

    // R5 mask write updates outputs at once
    wr(A_MASK, 32'hFFFF_FFFF);
    pulse_src(32'h4);
    chk("R5 masked irq_n", {31'b0, irq_n}, 32'd1);
    wr(A_MASK, 32'h0);
    chk("R5 unmask irq_n", {31'b0, irq_n}, 32'd0);
    wr(A_MASK, 32'hFFFF_FFFF);
    chk("R5 remask irq_n", {31'b0, irq_n}, 32'd1);
    clean();

    // R7 in-service load skips fast-routed sources
    wr(A_MASK, 32'h0); wr(A_ROUTE, 32'h8);
    pulse_src(32'h208);
    chk("R2 fiq_n bit3", {31'b0, fiq_n}, 32'd0);
    chk("R3 irq_n bit9", {31'b0, irq_n}, 32'd0);
    idle();
    rd(A_SVC, v); chk("R7 svc onehot", v, 32'h200);
    rd(A_IDX, v); chk("R7 svc index", v, 32'd9);
    // R11 read-only index
    wr(A_IDX, 32'h1F);
    rd(A_IDX, v); chk("R11 index unchanged", v, 32'd9);
    // R6 clear resets index
    wr(A_SRC, 32'h200);
    wr(A_SVC, 32'h200);
    rd(A_IDX, v); chk("R6 index zero", v, 32'd0);
    rd(A_SVC, v); chk("R6 svc cleared", v, 32'h0);
    clean();

    // R7 lowest index, R6 reload after clear
    wr(A_ROUTE, 32'h0);
    pulse_src(32'h50);
    idle();
    rd(A_IDX, v); chk("R7 lowest index", v, 32'd4);
    rd(A_SVC, v); chk("R7 lowest onehot", v, 32'h10);
    wr(A_SRC, 32'h10);
    wr(A_SVC, 32'h10);
    rd(A_IDX, v); chk("R6 index reset", v, 32'd0);
    rd(A_IDX, v); chk("R7 reload next", v, 32'd6);
    clean();

    // R8 R9 sub-source layer
    wr(A_SUBM, 32'h1EF);
    sub_req = 9'h111;
    idle();
    sub_req = '0;
    idle();
    chk("R9 parent irq_n", {31'b0, irq_n}, 32'd0);
    rd(A_SUB, v); chk("R8 sub pend impl", v, 32'h011);
    rd(A_SRC, v); chk("R9 only group1 parent", v, 32'h2000_0000);
    wr(A_SUB, 32'h010);
    rd(A_SUB, v); chk("R8 sub w1c", v, 32'h001);
    clean();
    chk("R9 irq_n after clear", {31'b0, irq_n}, 32'd1);
    wr(A_SUB, 32'h1FF);

    // R10 external layer
    wr(A_EXTM, 32'hFF7F_FFFF);
    ext_req = 32'h0180_001F;
    idle();
    ext_req = '0;
    idle();
    chk("R10 parent irq_n", {31'b0, irq_n}, 32'd0);
    rd(A_EXT, v); chk("R10 ext range", v, 32'h0080_0010);
    rd(A_SRC, v); chk("R10 parent bit5", v, 32'h20);
    wr(A_EXT, 32'hFFFF_FFFF);
    rd(A_EXT, v); chk("R10 ext w1c", v, 32'h0);
    clean();
    chk("R10 irq_n after clear", {31'b0, irq_n}, 32'd1);

    // R12 set wins over clear
    wr(A_MASK, 32'hFFFF_FFFF);
    src_req = 32'h80;
    wr(A_SRC, 32'h80);
    src_req = '0;
    rd(A_SRC, v); chk("R12 set kept", v, 32'h80);
    clean();

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule